// File: doc/BRIEF.md
# Interleaved Low-Activity Delay Line

This block delays a stream of words by a fixed number of clock cycles. Its ports behave like one long serial shift register. Inside, the register is not a single chain. It is split into `WAYS` lanes, and each lane is `DEPTH/WAYS` stages long. In any fast-clock cycle only one lane shifts, so each register stage is loaded at only `1/WAYS` of the sample rate. This reduces switching activity in the storage flops.

A round-robin write pointer picks the lane that takes the current input word. An output multiplexer, driven by the same pointer, shows the tail of the lane that is written next. That tail holds the oldest word still inside the block. The slower lane clocks are modelled as shift enables on the one fast clock. The total length and the lane count are fixed when the block is built, and `WAYS` must divide `DEPTH` exactly. Input and output are plain words taken and given every cycle, with no handshake, because the delay is counted in clock cycles.

Top module: `interleaved_delay_line`

## Requirements
- R1: The word on `data_in` at rising edge k appears on `data_out` after edge k+DEPTH-1 and stays there until edge k+DEPTH. This is the behaviour of a serial chain of DEPTH registers.
- R2: The R1 timing holds for every lane count that divides DEPTH evenly, including WAYS=1 and WAYS=DEPTH.
- R3: A synchronous reset (`rst` high at a rising edge) clears every stage. `data_out` is zero right after reset and remains zero until the first word written after reset has passed through all DEPTH stages.
- R4: Words on `data_in` at edges where `rst` is high are never stored and never reach `data_out`.
- R5: After reset the write pointer selects lane 0. It then steps 0, 1, …, WAYS-1, 0 once per cycle, and exactly one lane shifts in each cycle.
- R6: A lane that is not selected keeps all of its stages unchanged in that cycle.
- R7: A reset applied in the middle of a stream discards all earlier words. The data written afterwards again follows the R1 timing from a freshly aligned pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | DATA_W | Word entering the delay line this cycle |
| data_out | output | DATA_W | Word leaving the delay line, DEPTH cycles after entry |

## Verification
The bench runs instances for every lane count that divides 64, from 1 to 64. It compares each instance with a plain 64-deep serial model, so a pointer that starts on the wrong lane or a mux that chooses the current write lane's neighbour shows up as a shift of one or more samples. An instance whose lanes all shift every cycle would emit words about WAYS times too early, and an off-by-one in lane length would show a delay of DEPTH±WAYS. The bench also drives non-zero words during reset and applies reset in the middle of a stream. A design that captured data while in reset, or that kept the pointer phase across reset, would leak old words to the output or misalign the samples that follow.

// File: rtl/dl_pkg.sv
package dl_pkg;

  // Width of an index able to address n items (at least one bit).
  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dl_way_ptr.sv
module dl_way_ptr #(
  parameter int unsigned WAYS = 2,
  localparam int unsigned PW  = dl_pkg::sel_width(WAYS)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PW-1:0]   ptr,
  output logic [WAYS-1:0] shift_en
);

  localparam logic [PW-1:0] LAST = PW'(WAYS - 1);

  generate
    if (WAYS == 1) begin : g_single
      always_ff @(posedge clk) ptr <= '0;
    end else begin : g_ring
      always_ff @(posedge clk) begin
        if (rst)              ptr <= '0;
        else if (ptr == LAST) ptr <= '0;
        else                  ptr <= ptr + 1'b1;
      end
    end
  endgenerate

  // One-hot decode of the lane that takes the next word.
  always_comb begin
    shift_en = '0;
    shift_en[ptr] = 1'b1;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!rst && ptr == LAST) |=> ptr == '0); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!rst && ptr != LAST) |=> ptr == PW'($past(ptr) + 1'b1)); // R5

endmodule

// File: rtl/dl_lane.sv
module dl_lane #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STAGES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] tail
);

  logic [STAGES-1:0][DATA_W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)     stg <= '0;
        else if (en) stg[0] <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)     stg <= '0;
        else if (en) stg <= {stg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign tail = stg[STAGES-1];

  AST_LANE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (en && !rst) |=> stg[0] == $past(din)); // R1
  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !rst) |=> $stable(stg)); // R6

endmodule

// File: rtl/dl_tap_mux.sv
module dl_tap_mux #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WAYS   = 2,
  localparam int unsigned PW    = dl_pkg::sel_width(WAYS)
) (
  input  logic [PW-1:0]                sel,
  input  logic [WAYS-1:0][DATA_W-1:0]  tails,
  output logic [DATA_W-1:0]            dout
);

  generate
    if (WAYS == 1) begin : g_pass
      assign dout = tails[0];
    end else begin : g_sel
      always_comb dout = tails[sel];
    end
  endgenerate

endmodule

// File: rtl/interleaved_delay_line.sv
module interleaved_delay_line #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned WAYS   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out
);

  localparam int unsigned STAGES = DEPTH / WAYS;
  localparam int unsigned PW     = dl_pkg::sel_width(WAYS);

  logic [PW-1:0]               ptr;
  logic [WAYS-1:0]             shift_en;
  logic [WAYS-1:0][DATA_W-1:0] tails;

  dl_way_ptr #(.WAYS(WAYS)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .ptr      (ptr),
    .shift_en (shift_en)
  );

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_lane
      dl_lane #(.DATA_W(DATA_W), .STAGES(STAGES)) u_lane (
        .clk  (clk),
        .rst  (rst),
        .en   (shift_en[w]),
        .din  (data_in),
        .tail (tails[w])
      );
    end
  endgenerate

  // The lane written next holds the oldest word: show its tail.
  dl_tap_mux #(.DATA_W(DATA_W), .WAYS(WAYS)) u_mux (
    .sel   (ptr),
    .tails (tails),
    .dout  (data_out)
  );

  AST_ONE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    $onehot(shift_en)); // R5

endmodule

// File: tb/tb_interleaved_delay_line.sv
module tb_interleaved_delay_line;

  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 64;
  localparam int NINST = 7;   // WAYS = 1,2,4,...,64

  // Stimulus table: {mode[3:0], length[11:0], seed[15:0]}
  // mode 0 random, 1 constant, 2 walking one, 3 alternating, 4 counter
  localparam logic [31:0] STIM [6] = '{
    {4'd0, 12'd150, 16'h1234},
    {4'd1, 12'd100, 16'hA5A5},
    {4'd2, 12'd120, 16'h0001},
    {4'd3, 12'd100, 16'h5555},
    {4'd4, 12'd140, 16'h0100},
    {4'd0, 12'd200, 16'hBEEF}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] outs [NINST];
  logic [DW-1:0] hist [DEPTH];
  int checks = 0;
  int fails  = 0;
  logic [31:0] lcg = 32'h1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  generate
    for (genvar k = 0; k < NINST; k++) begin : g_p
      interleaved_delay_line #(.DATA_W(DW), .DEPTH(DEPTH), .WAYS(1 << k)) dut (
        .clk      (clk),
        .rst      (rst),
        .data_in  (din),
        .data_out (outs[k])
      );
    end
  endgenerate

  function automatic logic [DW-1:0] next_rand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[30:15];
  endfunction

  task automatic compare(input string tag);
    for (int k = 0; k < NINST; k++) begin
      checks++;
      if (outs[k] !== hist[DEPTH-1]) begin
        fails++;
        $display("FAIL %s ways=%0d actual=%h expected=%h", tag, 1 << k,
                 outs[k], hist[DEPTH-1]);
      end
    end
  endtask

  // Drive one word, let one edge pass, update the serial model, check.
  task automatic step(input logic [DW-1:0] x, input string tag);
    din = x;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) hist[i] = '0;
    end else begin
      for (int i = DEPTH-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) hist[i] = '0;
    // R3: reset state, with non-zero data present during reset (R4)
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(16'hFFFF, "R3 R4");
    rst = 1'b0;
    // R3 R5: outputs zero until first word crosses, then aligned from lane 0
    for (int i = 0; i < DEPTH + 8; i++) step(16'(i + 1), "R3 R5");

    // R1 R2 R6: table-driven streams for every lane count
    for (int t = 0; t < 6; t++) begin
      logic [3:0]  mode;
      logic [11:0] len;
      logic [15:0] seed;
      logic [DW-1:0] v;
      {mode, len, seed} = STIM[t];
      lcg = {16'h0, seed};
      for (int i = 0; i < int'(len); i++) begin
        case (mode)
          4'd0:    v = next_rand();
          4'd1:    v = seed;
          4'd2:    v = DW'(seed << (i % DW));
          4'd3:    v = (i % 2 == 1) ? ~seed : seed;
          default: v = seed + DW'(i);
        endcase
        step(v, "R1 R2 R6");
      end
    end

    // R7: reset in mid-stream with live data, then realignment
    for (int i = 0; i < 37; i++) step(next_rand(), "R1");
    rst = 1'b1;
    step(16'hDEAD, "R7");
    rst = 1'b0;
    for (int i = 0; i < DEPTH + 30; i++) step(next_rand(), "R7");

    // R4: two-cycle reset with data; zeros after must stay zero
    rst = 1'b1;
    step(16'hCAFE, "R4");
    step(16'hF00D, "R4");
    rst = 1'b0;
    for (int i = 0; i < DEPTH + 4; i++) step('0, "R4");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule